// File: doc/BRIEF.md
# Overcurrent Alert Threshold Monitor

This block watches the stream of conversion results from a current-sense ADC and raises sticky alert status bits when the measured current goes past a programmable eight-bit limit. The limit is compared against the most significant eight bits of each conversion word. Two trigger modes can be enabled independently. The single mode fires on any one conversion above the limit. The run mode fires only after four exceeding conversions in a row.

A separate path captures a level from an analog overcurrent comparator into its own latched status bit. Software reaches the block through a simple write port with three registers: an enable register, a limit register and a control register. All three can be read back at the ports. A write of the clear bit wipes the status bits one cycle later, and the clear bit then drops back to zero by itself. If the cause of an alert is still present and still enabled, its status bit sets again at once.

The active-low alert pin reflects any status bit whose source is enabled. A software force-off in the control register can hold the pin released, but only while a permit bit in the enable register is also set.

Top module: `ocp_alert_monitor`

## Requirements
- R1: After reset the enable register reads 0x04, the limit register reads 0xFF, the control register reads 0, both status bits are 0 and alert_n is 1.
- R2: A write with wr_sel=1 loads enable bits 4:0 from wr_data[4:0], wr_sel=2 loads the limit from wr_data[7:0], wr_sel=3 loads control bit 0 from wr_data[0], and wr_sel=0 changes no register. The new value reads back one cycle after the write edge.
- R3: A conversion exceeds the limit only when conv_data[ADC_W-1:ADC_W-8] is strictly greater than the limit. Equal is not an exceedance, so a limit of 0xFF never triggers.
- R4: With enable bit 0 set, a valid exceeding conversion sets status_adc on the same clock edge. Without a valid conversion, status_adc never goes from 0 to 1.
- R5: With enable bit 1 set, status_adc sets on the fourth consecutive valid exceeding conversion. Cycles without conv_valid do not break the run, and a valid non-exceeding conversion restarts it. Once four is reached the run count saturates, so each further exceeding conversion also sets status_adc.
- R6: With enable bit 2 set (its reset value is 1), oc_flag high at a clock edge sets status_oc.
- R7: Writing enable bit 4 as 1 clears status_adc and status_oc on the next clock edge, and bit 4 reads back 0 after that edge.
- R8: During the clearing edge, a status source that is still active and enabled sets its status bit again, so it does not read 0.
- R9: alert_n is 0 exactly when (status_adc is 1 and enable bit 0 or 1 is 1) or (status_oc is 1 and enable bit 2 is 1), unless force-off is active.
- R10: Force-off is active when control bit 0 and enable bit 3 are both 1. alert_n is then 1. Control bit 0 alone has no effect on alert_n.
- R11: Status bits are sticky: once set they stay 1, whatever the inputs and enables do, until a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 1 enable, 2 limit, 3 control |
| wr_data | input | 8 | Write data |
| conv_valid | input | 1 | Conversion result valid strobe |
| conv_data | input | ADC_W | Current-channel conversion word |
| oc_flag | input | 1 | Analog overcurrent comparator level |
| reg_enable | output | 5 | Enable register readback |
| reg_limit | output | 8 | Limit register readback |
| reg_ctrl | output | 1 | Control register readback |
| status_adc | output | 1 | Latched ADC alert status |
| status_oc | output | 1 | Latched overcurrent alert status |
| alert_n | output | 1 | Active-low alert pin |

## Verification
The hardest case to reach from the ports is the run trigger at its edges: three exceeding conversions followed by a conversion exactly at the limit, gaps without conv_valid inside a run, and a clear issued after the run count has saturated. In that last case the very next exceeding conversion must set the status again. Directed sequences build these runs on purpose, with conversion words whose top byte is one above, equal to, or below the limit. Constrained random traffic then mixes writes, clears and conversions near the limit. Every cycle is compared against a bench model of the registers, the run count and the status bits.

// File: rtl/ocp_alert_pkg.sv
package ocp_alert_pkg;

    localparam int LIM_W = 8;
    localparam int EN_W  = 5;

    localparam logic [1:0] SEL_ENABLE = 2'd1;
    localparam logic [1:0] SEL_LIMIT  = 2'd2;
    localparam logic [1:0] SEL_CTRL   = 2'd3;

    localparam int EN_SINGLE = 0;
    localparam int EN_RUN    = 1;
    localparam int EN_OC     = 2;
    localparam int EN_PERMIT = 3;
    localparam int EN_CLEAR  = 4;

    localparam logic [EN_W-1:0]  ENABLE_RST = 5'b00100;
    localparam logic [LIM_W-1:0] LIMIT_RST  = 8'hFF;

    typedef struct packed {
        logic [EN_W-1:0]  enable;
        logic [LIM_W-1:0] limit;
        logic             force_off;
    } cfg_t;

    typedef struct packed {
        logic adc;
        logic oc;
    } status_t;

endpackage

// File: rtl/ocp_cfg_regs.sv
module ocp_cfg_regs
    import ocp_alert_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [LIM_W-1:0] wr_data,
    output cfg_t             cfg
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        // the clear command lives for one cycle only
        cfg_d.enable[EN_CLEAR] = 1'b0;
        if (wr_en) begin
            case (wr_sel)
                SEL_ENABLE: cfg_d.enable    = wr_data[EN_W-1:0];
                SEL_LIMIT:  cfg_d.limit     = wr_data;
                SEL_CTRL:   cfg_d.force_off = wr_data[0];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.enable    <= ENABLE_RST;
            cfg_q.limit     <= LIMIT_RST;
            cfg_q.force_off <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/ocp_run_tracker.sv
module ocp_run_tracker
    import ocp_alert_pkg::*;
#(
    parameter int ADC_W   = 12,
    parameter int RUN_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_valid,
    input  logic [ADC_W-1:0] conv_data,
    input  logic [LIM_W-1:0] limit,
    output logic             hit_single,
    output logic             hit_run
);

    localparam int CNT_W = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(RUN_LEN);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RUN_LEN - 1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } run_t;

    run_t run_d, run_q;
    logic above;

    always_comb begin
        above      = conv_data[ADC_W-1 -: LIM_W] > limit;
        hit_single = conv_valid && above;
        hit_run    = conv_valid && above && (run_q.count >= CNT_LAST);
        run_d      = run_q;
        if (conv_valid) begin
            if (!above) begin
                run_d.count = '0;
            end else if (run_q.count != CNT_MAX) begin
                run_d.count = run_q.count + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q.count <= '0;
        end else begin
            run_q <= run_d;
        end
    end

endmodule

// File: rtl/ocp_status_flags.sv
module ocp_status_flags
    import ocp_alert_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  cfg_t    cfg,
    input  logic    hit_single,
    input  logic    hit_run,
    input  logic    oc_flag,
    output status_t status,
    output logic    alert_n
);

    status_t st_d, st_q;
    logic    set_adc, set_oc, want_alert, muted;

    always_comb begin
        set_adc = (cfg.enable[EN_SINGLE] && hit_single) ||
                  (cfg.enable[EN_RUN] && hit_run);
        set_oc  = cfg.enable[EN_OC] && oc_flag;
        st_d    = st_q;
        if (cfg.enable[EN_CLEAR]) begin
            st_d.adc = 1'b0;
            st_d.oc  = 1'b0;
        end
        st_d.adc = st_d.adc | set_adc;
        st_d.oc  = st_d.oc  | set_oc;

        want_alert = (st_q.adc && (cfg.enable[EN_SINGLE] || cfg.enable[EN_RUN])) ||
                     (st_q.oc && cfg.enable[EN_OC]);
        muted      = cfg.force_off && cfg.enable[EN_PERMIT];
        alert_n    = !(want_alert && !muted);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.adc <= 1'b0;
            st_q.oc  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status = st_q;

endmodule

// File: rtl/ocp_alert_monitor.sv
module ocp_alert_monitor
    import ocp_alert_pkg::*;
#(
    parameter int ADC_W   = 12,
    parameter int RUN_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [7:0]       wr_data,
    input  logic             conv_valid,
    input  logic [ADC_W-1:0] conv_data,
    input  logic             oc_flag,
    output logic [4:0]       reg_enable,
    output logic [7:0]       reg_limit,
    output logic             reg_ctrl,
    output logic             status_adc,
    output logic             status_oc,
    output logic             alert_n
);

    cfg_t    cfg;
    status_t status;
    logic    hit_single, hit_run;

    ocp_cfg_regs u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    ocp_run_tracker #(
        .ADC_W   (ADC_W),
        .RUN_LEN (RUN_LEN)
    ) u_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_valid (conv_valid),
        .conv_data  (conv_data),
        .limit      (cfg.limit),
        .hit_single (hit_single),
        .hit_run    (hit_run)
    );

    ocp_status_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg),
        .hit_single (hit_single),
        .hit_run    (hit_run),
        .oc_flag    (oc_flag),
        .status     (status),
        .alert_n    (alert_n)
    );

    assign reg_enable = cfg.enable;
    assign reg_limit  = cfg.limit;
    assign reg_ctrl   = cfg.force_off;
    assign status_adc = status.adc;
    assign status_oc  = status.oc;

endmodule

// File: rtl/ocp_alert_checker.sv
module ocp_alert_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] wr_sel,
    input logic [7:0] wr_data,
    input logic       conv_valid,
    input logic       oc_flag,
    input logic [4:0] reg_enable,
    input logic       reg_ctrl,
    input logic       status_adc,
    input logic       status_oc,
    input logic       alert_n
);

    logic clear_rewrite;
    assign clear_rewrite = wr_en && (wr_sel == 2'd1) && wr_data[4];

    AST_CLEAR_SELF_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_enable[4] && !clear_rewrite) |=> !reg_enable[4]); // R7

    AST_CLEAR_WIPES_ADC: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_enable[4] && !conv_valid) |=> !status_adc); // R7

    AST_OC_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_flag && reg_enable[2]) |=> status_oc); // R8

    AST_ADC_NEEDS_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_adc && !conv_valid) |=> !status_adc); // R4

    AST_ADC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status_adc && !reg_enable[4]) |=> status_adc); // R11

    AST_OC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status_oc && !reg_enable[4]) |=> status_oc); // R11

    AST_FORCE_OFF_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_ctrl && reg_enable[3]) |-> alert_n); // R10

    AST_IDLE_NO_ALERT: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_adc && !status_oc) |-> alert_n); // R9

endmodule

bind ocp_alert_monitor ocp_alert_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .conv_valid (conv_valid),
    .oc_flag    (oc_flag),
    .reg_enable (reg_enable),
    .reg_ctrl   (reg_ctrl),
    .status_adc (status_adc),
    .status_oc  (status_oc),
    .alert_n    (alert_n)
);

// File: tb/ocp_alert_monitor_tb.sv
module ocp_alert_monitor_tb;

    localparam int ADC_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_sel = '0;
    logic [7:0]       wr_data = '0;
    logic             conv_valid = 1'b0;
    logic [ADC_W-1:0] conv_data = '0;
    logic             oc_flag = 1'b0;
    logic [4:0]       reg_enable;
    logic [7:0]       reg_limit;
    logic             reg_ctrl, status_adc, status_oc, alert_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model of the requirements
    logic [4:0] m_en;
    logic [7:0] m_lim;
    logic       m_ctrl, m_adc, m_oc;
    int         m_run;

    always #2.5 clk = ~clk;

    ocp_alert_monitor #(.ADC_W(ADC_W), .RUN_LEN(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .conv_valid(conv_valid), .conv_data(conv_data),
        .oc_flag(oc_flag), .reg_enable(reg_enable), .reg_limit(reg_limit),
        .reg_ctrl(reg_ctrl), .status_adc(status_adc), .status_oc(status_oc),
        .alert_n(alert_n)
    );

    function automatic logic exp_alert_n();
        logic act;
        act = (m_adc && (m_en[0] || m_en[1])) || (m_oc && m_en[2]);
        return !(act && !(m_ctrl && m_en[3]));
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        chk(tag, "R2 reg_enable", int'(reg_enable), int'(m_en));
        chk(tag, "R2 reg_limit", int'(reg_limit), int'(m_lim));
        chk(tag, "R2 reg_ctrl", int'(reg_ctrl), int'(m_ctrl));
        chk(tag, "R4/R5 status_adc", int'(status_adc), int'(m_adc));
        chk(tag, "R6 status_oc", int'(status_oc), int'(m_oc));
        chk(tag, "R9 alert_n", int'(alert_n), int'(exp_alert_n()));
    endtask

    // drive one cycle at the falling edge, advance the model, compare next fall
    task automatic cyc(string tag, logic we, logic [1:0] ws, logic [7:0] wd,
                       logic cv, logic [7:0] top, logic ocf);
        logic above, clr, s_adc, s_oc;
        wr_en = we; wr_sel = ws; wr_data = wd;
        conv_valid = cv; conv_data = {top, 4'h5}; oc_flag = ocf;
        above = top > m_lim;                         // R3 strictly greater
        s_adc = (m_en[0] && cv && above) ||
                (m_en[1] && cv && above && (m_run >= 3));
        s_oc  = m_en[2] && ocf;
        clr   = m_en[4];
        if (cv) m_run = above ? ((m_run < 4) ? m_run + 1 : 4) : 0;
        m_adc = (clr ? 1'b0 : m_adc) | s_adc;
        m_oc  = (clr ? 1'b0 : m_oc) | s_oc;
        m_en[4] = 1'b0;
        if (we) begin
            case (ws)
                2'd1: m_en = wd[4:0];
                2'd2: m_lim = wd;
                2'd3: m_ctrl = wd[0];
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(string tag, int n);
        for (int i = 0; i < n; i++) cyc(tag, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic wr(string tag, logic [1:0] s, logic [7:0] d);
        cyc(tag, 1, s, d, 0, 0, 0);
    endtask

    task automatic conv(string tag, logic [7:0] top);
        cyc(tag, 0, 0, 0, 1, top, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0C0FFEE1));
        m_en = 5'b00100; m_lim = 8'hFF; m_ctrl = 0; m_adc = 0; m_oc = 0; m_run = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 reset");

        // R3: limit 0xFF, top byte 0xFF equals it and never triggers
        wr("R2 single enable", 2'd1, 8'h01);
        conv("R3 equal to 0xFF limit", 8'hFF);
        wr("R2 limit 0x80", 2'd2, 8'h80);
        conv("R3 equal to limit", 8'h80);
        conv("R4 single trigger", 8'h81);
        idle("R11 sticky adc", 2);
        cyc("R2 sel0 ignored", 1, 2'd0, 8'hAA, 0, 0, 0);

        // R7 clear then R5 run mode
        wr("R7 clear + run mode", 2'd1, 8'h12);
        idle("R7 clear completes", 1);
        conv("R5 run 1", 8'h81);
        idle("R5 gap", 1);
        conv("R5 run 2", 8'h90);
        conv("R5 run 3", 8'hFF);
        conv("R5 run broken at equal", 8'h80);
        conv("R5 run 1 again", 8'h81);
        conv("R5 run 2 again", 8'h81);
        conv("R5 run 3 again", 8'h81);
        conv("R5 run 4 sets", 8'h81);
        conv("R5 saturated", 8'h81);
        wr("R7 clear saturated", 2'd1, 8'h12);
        idle("R7 cleared", 1);
        conv("R5 saturated re-set", 8'h81);

        // R6 / R8 overcurrent capture and persistent re-set
        wr("R6 oc enable only", 2'd1, 8'h04);
        cyc("R6 oc capture", 0, 0, 0, 0, 0, 1);
        idle("R11 oc sticky", 2);
        wr("R8 clear request", 2'd1, 8'h14);
        cyc("R8 oc persists through clear", 0, 0, 0, 0, 0, 1);
        wr("R7 clear oc gone", 2'd1, 8'h14);
        idle("R7 oc cleared", 1);

        // R10 force-off gating
        cyc("R6 oc set again", 0, 0, 0, 0, 0, 1);
        wr("R10 ctrl alone", 2'd3, 8'h01);
        wr("R10 permit on", 2'd1, 8'h0C);
        wr("R10 ctrl off", 2'd3, 8'h00);
        wr("R9 oc disabled hides alert", 2'd1, 8'h00);

        // constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            logic       we;
            logic [1:0] ws;
            logic [7:0] wd, top;
            we  = ($urandom_range(0, 7) == 0);
            ws  = 2'($urandom_range(0, 3));
            wd  = 8'($urandom);
            if (ws == 2'd2) wd = 8'($urandom_range(8'h60, 8'hA0));
            top = 8'(m_lim + $urandom_range(0, 4) - 2);
            cyc("R4 R5 R6 R7 R9 R10 random", we, ws, wd,
                ($urandom_range(0, 2) != 0), top, ($urandom_range(0, 15) == 0));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule